// File: doc/BRIEF.md
# Page-Mode Nonvolatile Memory Write Controller

This block is the control logic that sits on the device side of a byte-wide nonvolatile memory with page-mode writes. A host drives active-low chip-enable, write-enable and output-enable strobes, an address bus and a data bus. The strobes are sampled on the block clock. Each write strobe pair latches one byte into a page buffer. The page buffer holds `2**PAGE_W` bytes, which is 32 with the default setting. A retriggerable load window follows each byte. When the window expires with no new write, an internally timed programming phase starts. At the end of that phase the written bytes of the page are copied into a synchronous RAM that stands in for the nonvolatile array.

While a page is being loaded or programmed, reads return a status byte in place of array data. The status byte holds a polling bit (the complement of the last written MSB), a toggle bit that flips on every read, and a load-window flag. The ready/busy output is low for the whole programming phase.

The host side is a strobe bus and has no valid/ready handshake. The block never applies back-pressure. The host finds out when the block is busy from `rdy_n` or from the status bits, and any write strobe it issues while programming runs is dropped. Timer lengths are clock-cycle parameters. The default array depth is 2K bytes, and a full 8K part sets `ADDR_W` to 13.

Top module: `eep_page_ctrl`

## Requirements
- R1: After reset, `rdy_n` is 1, `dout_en` is 0, `dout` is 0, and no load or programming phase is in progress.
- R2: A write occurs only while `ce_n` and `we_n` are both low and `oe_n` is high. Strobes with `oe_n` low write nothing and open no load window.
- R3: The address of a byte is sampled in the first clock where the write condition holds, which is the later of the two falling strobes. Its data is sampled in the first clock where the condition no longer holds, which is the earlier of the two rising strobes. Bus values between those two clocks have no effect.
- R4: Bytes written during one load are stored in the page fixed by the first byte, at offset `addr[PAGE_W-1:0]`, and read back unchanged once programming completes.
- R5: The load window restarts when each byte ends. Programming begins exactly `LOAD_CYC` clocks after the last byte ends, so `rdy_n` is still 1 after `LOAD_CYC-1` clocks and is 0 after `LOAD_CYC` clocks.
- R6: `rdy_n` stays 0 for `PROG_CYC + 2**PAGE_W` clocks and then returns to 1 with the block idle.
- R7: Write strobes that end while `rdy_n` is 0 are dropped and change no array location.
- R8: While a page is loading or programming, bit 7 of a read is the complement of bit 7 of the last accepted byte. Once the block is idle, reads return array data again.
- R9: During load or programming, bit 6 of a read is 1 on the first read after a page opens and then alternates on each new read.
- R10: During load or programming, bit 5 of a read is 1 while the load window is open and 0 during programming, and bits 4..0 are 0.
- R11: A byte whose upper address bits differ from the open page is stored in the open page at its low offset. The other page is left unchanged.
- R12: Offsets of a page that were not written during a load keep their previous contents.
- R13: `dout_en` and `dout` follow a read condition (`ce_n`=0, `oe_n`=0, `we_n`=1) one clock later. When there is no read condition, `dout_en` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the host |
| dout | output | DATA_W | Read data or status byte |
| dout_en | output | 1 | High while `dout` is driven onto the bus |
| rdy_n | output | 1 | Low while the programming phase runs |

## Verification
Each result is checked at the clock where it falls due. Read data and `dout_en` appear one clock after the read condition is first sampled. `rdy_n` drops `LOAD_CYC` clocks after the edge that ends the last byte and rises `PROG_CYC + 32` clocks after that. The bench keeps a cycle counter on the rising edge and records the edge at which each byte ends. It then samples outputs on falling edges, at the counts just before and just after each due edge. This pins every transition to one exact clock.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } eep_state_e;
endpackage

// File: rtl/eep_strobe_dec.sv
// Samples the host strobes and derives write/read conditions and their edges.
module eep_strobe_dec #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_act,
  output logic              wr_end,
  output logic              rd_act,
  output logic              rd_start,
  output logic [ADDR_W-1:0] addr_lat
);
  logic wr_q;
  logic rd_q;
  logic wr_start;

  assign wr_act   = !ce_n && !we_n && oe_n;
  assign rd_act   = !ce_n && !oe_n && we_n;
  assign wr_start = wr_act && !wr_q;
  assign wr_end   = wr_q && !wr_act;
  assign rd_start = rd_act && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      addr_lat <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_start) addr_lat <= addr;
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: one lane per byte offset with its own written flag.
module eep_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvld
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_BYTES-1:0] vld;
  logic [DATA_W-1:0]     lanes [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic              v;
    logic [DATA_W-1:0] b;
    logic              hit;

    assign hit = we && (widx == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= 1'b0;
        b <= '0;
      end else if (hit) begin
        v <= 1'b1;
        b <= wdata;
      end else if (clr) begin
        v <= 1'b0;
      end
    end

    assign vld[g]   = v;
    assign lanes[g] = b;
  end

  assign rdata = lanes[ridx];
  assign rvld  = vld[ridx];
endmodule

// File: rtl/eep_wr_seq.sv
// Write sequencer: load window, programming timer and commit walk.
module eep_wr_seq
  import eep_pkg::*;
#(
  parameter int LOAD_CYC = 10000,
  parameter int PROG_CYC = 500000,
  parameter int PAGE_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic              byte_stb,
  output eep_state_e        state,
  output logic              accept,
  output logic              open_pg,
  output logic              commit_we,
  output logic [PAGE_W-1:0] commit_idx
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MAX_CYC    = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;

  assign accept    = byte_stb && ((state == ST_IDLE) || (state == ST_LOAD));
  assign open_pg   = byte_stb && (state == ST_IDLE);
  assign commit_we = (state == ST_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      commit_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (byte_stb) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        ST_LOAD: begin
          if (wr_act || byte_stb) begin
            cnt <= '0;
          end else if (cnt == CNT_W'(LOAD_CYC - 1)) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt == CNT_W'(PROG_CYC - 1)) begin
            state      <= ST_COMMIT;
            cnt        <= '0;
            commit_idx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (commit_idx == PAGE_W'(PAGE_BYTES - 1)) begin
            state      <= ST_IDLE;
            commit_idx <= '0;
          end else begin
            commit_idx <= commit_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_array.sv
// Synchronous RAM standing in for the nonvolatile array.
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 5,
  parameter int LOAD_CYC = 10000,
  parameter int PROG_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rdy_n
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic              wr_act;
  logic              wr_end;
  logic              rd_act;
  logic              rd_start;
  logic [ADDR_W-1:0] addr_lat;
  eep_state_e        state;
  logic              accept;
  logic              open_pg;
  logic              commit_we;
  logic [PAGE_W-1:0] commit_idx;
  logic [DATA_W-1:0] buf_rdata;
  logic              buf_rvld;
  logic [DATA_W-1:0] ram_rdata;
  logic [PG_W-1:0]   page_q;
  logic              last_msb;
  logic              tgl;
  logic              tgl_n;
  logic              in_load;
  logic              busy;
  logic              stat_mode;
  logic              dout_en_q;
  logic              stat_sel_q;
  logic [DATA_W-1:0] stat_q;

  eep_strobe_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .wr_act   (wr_act),
    .wr_end   (wr_end),
    .rd_act   (rd_act),
    .rd_start (rd_start),
    .addr_lat (addr_lat)
  );

  eep_wr_seq #(
    .LOAD_CYC (LOAD_CYC),
    .PROG_CYC (PROG_CYC),
    .PAGE_W   (PAGE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_act     (wr_act),
    .byte_stb   (wr_end),
    .state      (state),
    .accept     (accept),
    .open_pg    (open_pg),
    .commit_we  (commit_we),
    .commit_idx (commit_idx)
  );

  eep_page_buf #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (open_pg),
    .we    (accept),
    .widx  (addr_lat[PAGE_W-1:0]),
    .wdata (din),
    .ridx  (commit_idx),
    .rdata (buf_rdata),
    .rvld  (buf_rvld)
  );

  eep_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (commit_we && buf_rvld),
    .waddr ({page_q, commit_idx}),
    .wdata (buf_rdata),
    .raddr (addr),
    .rdata (ram_rdata)
  );

  assign in_load   = (state == ST_LOAD);
  assign busy      = (state == ST_PROG) || (state == ST_COMMIT);
  assign stat_mode = (state != ST_IDLE);
  assign rdy_n     = !busy;
  assign tgl_n     = (rd_start && stat_mode) ? !tgl : tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      last_msb   <= 1'b0;
      tgl        <= 1'b0;
      dout_en_q  <= 1'b0;
      stat_sel_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      if (open_pg) page_q <= addr_lat[ADDR_W-1:PAGE_W];
      if (accept) last_msb <= din[DATA_W-1];
      tgl        <= open_pg ? 1'b0 : tgl_n;
      dout_en_q  <= rd_act;
      stat_sel_q <= rd_act && stat_mode;
      stat_q     <= {!last_msb, tgl_n, in_load, {(DATA_W-3){1'b0}}};
    end
  end

  assign dout_en = dout_en_q;
  assign dout    = !dout_en_q ? '0 : (stat_sel_q ? stat_q : ram_rdata);
endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
  parameter int PG_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            we_n,
  input logic            oe_n,
  input logic            rdy_n,
  input logic            dout_en,
  input logic            in_load,
  input logic            commit_we,
  input logic [PG_W-1:0] page_q
);
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rdy_n); // R1

  AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(in_load)); // R5

  AST_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> !rdy_n); // R6

  AST_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $past(commit_we)); // R6

  AST_PAGE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && $past(!rdy_n)) |-> $stable(page_q)); // R7

  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!ce_n && !oe_n && we_n)); // R13

  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && !oe_n && we_n) |-> dout_en); // R13
endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(.PG_W(PG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .rdy_n     (rdy_n),
  .dout_en   (dout_en),
  .in_load   (in_load),
  .commit_we (commit_we),
  .page_q    (page_q)
);

// File: tb/eep_page_ctrl_bench.sv
module eep_page_ctrl_bench;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int PW  = 5;
  localparam int LC  = 20;
  localparam int PC  = 40;
  localparam int PB  = 1 << PW;
  localparam int NPG = 1 << (AW - PW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          rdy_n;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NPG*PB];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eep_page_ctrl #(
    .ADDR_W   (AW),
    .DATA_W   (DW),
    .PAGE_W   (PW),
    .LOAD_CYC (LC),
    .PROG_CYC (PC)
  ) u_eep_page_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en),
    .rdy_n   (rdy_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge right after the
  // rising edge that ends the byte (cyc == pe).
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit ce_last, output int pe);
    logic [AW-1:0] ja;
    ja = a ^ AW'(8'hA5);
    if (!ce_last) begin
      ce_n = 1'b0; we_n = 1'b0; addr = a; din = ~d;
      @(negedge clk);
      addr = ja; din = d;
      @(negedge clk);
      we_n = 1'b1; pe = cyc + 1;
      @(negedge clk);
      ce_n = 1'b1;
    end else begin
      we_n = 1'b0; addr = ja;
      @(negedge clk);
      ce_n = 1'b0; addr = a; din = ~d;
      @(negedge clk);
      addr = ja; din = d;
      @(negedge clk);
      ce_n = 1'b1; pe = cyc + 1;
      @(negedge clk);
      we_n = 1'b1;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] stat(input logic msb, input logic t, input logic ld);
    return {~msb, t, ld, 5'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int pe;
    logic [DW-1:0] d;
    logic [DW-1:0] last_d;
    logic en;
    int lows;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdy_n after reset", int'(rdy_n), 1);
    check("R1 dout_en after reset", int'(dout_en), 0);
    check("R1 dout after reset", int'(dout), 0);

    // R4 R3 R5 R6 R7 R8 R9 R10: fill every page, both strobe orders
    for (int p = 0; p < NPG; p++) begin
      pe = 0;
      last_d = '0;
      for (int i = 0; i < PB; i++) begin
        logic [AW-1:0] a;
        a = AW'(p * PB + i);
        last_d = DW'(p * 53 + i * 29 + 7);
        wr(a, last_d, i[0], pe);
        model[a] = last_d;
      end
      rd(AW'(p * PB), d, en);
      check("R10 R8 R9 first status read in load", int'(d), int'(stat(last_d[7], 1'b1, 1'b1)));
      check("R13 dout_en during read", int'(en), 1);
      check("R13 dout_en released", int'(dout_en), 0);
      rd(AW'(p * PB), d, en);
      check("R9 second status read toggles", int'(d), int'(stat(last_d[7], 1'b0, 1'b1)));
      wait_until(pe + LC - 1);
      check("R5 still ready one clock before window closes", int'(rdy_n), 1);
      wait_until(pe + LC);
      check("R5 busy when window closes", int'(rdy_n), 0);
      rd(AW'(p * PB + 1), d, en);
      check("R10 R8 status read while programming", int'(d), int'(stat(last_d[7], 1'b1, 1'b0)));
      begin
        int pe_ign;
        wr(AW'(p * PB), ~model[p * PB], 1'b0, pe_ign);
      end
      wait_until(pe + LC + PC + PB - 1);
      check("R6 busy on last commit clock", int'(rdy_n), 0);
      wait_until(pe + LC + PC + PB);
      check("R6 ready after programming", int'(rdy_n), 1);
      rd(AW'(p * PB + PB - 1), d, en);
      check("R8 array data after completion", int'(d), int'(last_d));
    end

    // R4 R3 R7: sweep every location
    for (int a = 0; a < NPG * PB; a++) begin
      rd(AW'(a), d, en);
      check($sformatf("R4 readback addr %0h", a), int'(d), int'(model[a]));
    end

    // R11 R12 R5: partial page with an off-page byte
    wr(AW'(2 * PB + 3), 8'h3C, 1'b0, pe);
    model[2 * PB + 3] = 8'h3C;
    wr(AW'(2 * PB + 17), 8'hC3, 1'b1, pe);
    model[2 * PB + 17] = 8'hC3;
    wr(AW'(5 * PB + 9), 8'h5A, 1'b0, pe);
    model[2 * PB + 9] = 8'h5A;
    rd(AW'(0), d, en);
    check("R8 R9 R10 status after off-page byte", int'(d), int'(stat(1'b0, 1'b1, 1'b1)));
    wait_until(pe + LC - 1);
    check("R5 window restarted by each byte", int'(rdy_n), 1);
    wait_until(pe + LC + PC + PB);
    check("R6 ready after partial page", int'(rdy_n), 1);
    for (int i = 0; i < PB; i++) begin
      rd(AW'(2 * PB + i), d, en);
      check($sformatf("R12 R11 open page offset %0d", i), int'(d), int'(model[2 * PB + i]));
      rd(AW'(5 * PB + i), d, en);
      check($sformatf("R11 other page offset %0d", i), int'(d), int'(model[5 * PB + i]));
    end

    // R2: write strobes with oe_n low
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = AW'(7 * PB + 4); din = ~model[7 * PB + 4];
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    lows = 0;
    for (int k = 0; k < LC + PC + PB + 10; k++) begin
      @(negedge clk);
      if (!rdy_n) lows++;
    end
    check("R2 no programming from oe_n-low strobes", lows, 0);
    rd(AW'(7 * PB + 4), d, en);
    check("R2 location unchanged", int'(d), int'(model[7 * PB + 4]));
    check("R13 dout zero when not reading", int'(dout), 0);

    finish_run();
  end
endmodule